// File: doc/BRIEF.md
# Programmable PLL Divide-Ratio Counters

This block sits inside a frequency synthesiser loop and produces the two divided clocks that a phase detector compares. The reference path counts the incoming reference clock down by a reference ratio. The feedback path counts the oscillator clock down by a feedback ratio. When the loop is locked, the output frequency equals the reference frequency times the feedback ratio divided by the reference ratio.

The ratios come from one of two sources. With programming enabled, an 8-bit feedback field and a 6-bit reference field set the ratios through offset and scaling formulas, and a bypass flag can force the reference ratio to one. With programming disabled, the programmed fields are ignored. A single select pin then picks one of two fixed multipliers, and the reference ratio is one.

Each divider reloads only when its count reaches zero. A ratio change therefore never cuts a running period short. The resolved ratios are also driven out as ports.

Top module: `pll_div_core`

## Requirements
- R1: When `prog_en` is 1, `fb_ratio` equals (`cfg_p` + 3) × 2. This gives 6 for `cfg_p` = 0 and 516 for `cfg_p` = 255.
- R2: When `prog_en` is 1 and `q_bypass` is 0, `ref_ratio` equals `cfg_q` + 2. This gives 2 for `cfg_q` = 0 and 65 for `cfg_q` = 63.
- R3: When `prog_en` is 1 and `q_bypass` is 1, `ref_ratio` is 1 whatever the value of `cfg_q`.
- R4: When `prog_en` is 0, `cfg_p`, `cfg_q` and `q_bypass` have no effect. In that mode `ref_ratio` is 1, and `fb_ratio` is 16 with `mult_sel` = 0 or 8 with `mult_sel` = 1.
- R5: While `rst_n` is low at a clock edge, `fb_pulse`, `ref_pulse` and `fb_half` are all 0.
- R6: `fb_pulse` is high for exactly one `vco_clk` cycle every N cycles, where N is the feedback ratio in force. `ref_pulse` behaves the same way on `ref_clk`. A ratio of 1 keeps the pulse high on every cycle.
- R7: A ratio change is taken only at the divider's next terminal count. The period already running completes with the old ratio, and the following periods use the new ratio.
- R8: `fb_half` inverts at every feedback terminal count and again halfway through the period. For an even ratio N it is high for N/2 `vco_clk` cycles.
- R9: On the first rising edge of each divider's clock after `rst_n` goes high, that divider reaches terminal count. Its pulse is high in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Oscillator clock that drives the feedback divider |
| ref_clk | input | 1 | Reference clock that drives the reference divider |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each clock domain |
| prog_en | input | 1 | 1: ratios come from the programmed fields; 0: ratios come from the select pin |
| mult_sel | input | 1 | Fallback multiplier select: 0 gives ×16, 1 gives ×8 (pulled high on the board) |
| q_bypass | input | 1 | Forces the reference ratio to 1 in programmed mode |
| cfg_p | input | 8 | Programmed feedback field |
| cfg_q | input | 6 | Programmed reference field |
| fb_pulse | output | 1 | One-cycle feedback terminal-count pulse |
| fb_half | output | 1 | Feedback square wave with about 50% duty cycle |
| ref_pulse | output | 1 | One-cycle reference terminal-count pulse |
| fb_ratio | output | 10 | Resolved feedback ratio |
| ref_ratio | output | 7 | Resolved reference ratio |

## Verification
The bench builds the block with its default parameters: full 8-bit and 6-bit fields, an offset of 3 and a scale of 2 on the feedback path, an offset of 2 on the reference path, and fixed multipliers of 16 and 8. These values let the bench reach both ends of each programmed range: 6 and 516 on feedback, 2 and 65 on reference. They also cover the ratio-of-one case, where the reference pulse never falls. Every ratio change is made just after a feedback pulse, so the bench can check that the old period completes. A change from the longest feedback period to a short one shows that a running count is never truncated.

// File: rtl/pllcnt_pkg.sv
// Package pllcnt_pkg
// Shared types for the PLL divide-ratio counters.
// Assumes: nothing beyond standard SystemVerilog.
package pllcnt_pkg;

    // Where the in-force ratios come from.
    typedef enum logic {
        SRC_PIN  = 1'b0,
        SRC_PROG = 1'b1
    } ratio_src_e;

endpackage

// File: rtl/pll_ratio_sel.sv
// Module pll_ratio_sel
// Resolves the feedback and reference divide ratios from the programmed fields
// or, when programming is off, from the fallback multiplier pin.
// Assumes: the output widths are large enough for the largest ratio (the top
// derives them from the same parameters).
module pll_ratio_sel
    import pllcnt_pkg::*;
#(
    parameter int P_W       = 8,
    parameter int Q_W       = 6,
    parameter int FB_W      = 10,
    parameter int REF_W     = 7,
    parameter int FB_OFS    = 3,
    parameter int FB_SCALE  = 2,
    parameter int Q_OFS     = 2,
    parameter int PIN0_MULT = 16,
    parameter int PIN1_MULT = 8
) (
    input  logic [P_W-1:0]   cfg_p,
    input  logic [Q_W-1:0]   cfg_q,
    input  logic             prog_en,
    input  logic             q_bypass,
    input  logic             mult_sel,
    output logic [FB_W-1:0]  fb_ratio,
    output logic [REF_W-1:0] ref_ratio
);

    ratio_src_e        src;
    logic [FB_W-1:0]   fb_prog;
    logic [REF_W-1:0]  ref_prog;
    logic [FB_W-1:0]   fb_pin;

    assign src = prog_en ? SRC_PROG : SRC_PIN;

    // Programmed feedback ratio: offset and then scale.
    always_comb begin
        fb_prog = (FB_W'(cfg_p) + FB_W'(FB_OFS)) * FB_W'(FB_SCALE);
    end

    // Programmed reference ratio: offset, or unity when bypassed.
    always_comb begin
        if (q_bypass) ref_prog = REF_W'(1);
        else          ref_prog = REF_W'(cfg_q) + REF_W'(Q_OFS);
    end

    // Fallback multiplier chosen by the pin.
    always_comb begin
        fb_pin = mult_sel ? FB_W'(PIN1_MULT) : FB_W'(PIN0_MULT);
    end

    // Final source selection.
    always_comb begin
        unique case (src)
            SRC_PROG: begin
                fb_ratio  = fb_prog;
                ref_ratio = ref_prog;
            end
            default: begin
                fb_ratio  = fb_pin;
                ref_ratio = REF_W'(1);
            end
        endcase
    end

endmodule

// File: rtl/pll_down_div.sv
// Module pll_down_div
// Down-counter divider. It reloads with ratio-1 at terminal count (count == 0)
// and registers a one-cycle pulse there. A ratio change is sampled only at
// reload. An optional square-wave output flips at terminal count and at the
// half-way count of the ratio in force.
// Assumes: ratio_in is stable for a few cycles around a reload; 0 is treated as 1.
module pll_down_div #(
    parameter int CNT_W    = 10,
    parameter bit HAS_HALF = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ratio_in,
    output logic             tc_pulse,
    output logic             half_out
);

    logic [CNT_W-1:0] ratio_eff;
    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;
    logic             at_tc;

    assign ratio_eff = (ratio_in == '0) ? CNT_W'(1) : ratio_in;
    assign at_tc     = (cnt_q == '0);
    assign tc_pulse  = pulse_q;

    // Count down; reload and flag the pulse at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= at_tc;
            if (at_tc) cnt_q <= ratio_eff - CNT_W'(1);
            else       cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    generate
        if (HAS_HALF) begin : g_half
            logic [CNT_W-1:0] act_q;
            logic             tog_q;

            // Hold the in-force ratio and toggle at the reload and half-way points.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    act_q <= CNT_W'(1);
                    tog_q <= 1'b0;
                end else begin
                    if (at_tc) act_q <= ratio_eff;
                    if (at_tc || (cnt_q == (act_q >> 1))) tog_q <= ~tog_q;
                end
            end

            assign half_out = tog_q;
        end else begin : g_nohalf
            assign half_out = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pll_div_core.sv
// Module pll_div_core
// Top level of the PLL divide-ratio counters. It resolves the ratios, then runs
// the feedback divider on vco_clk and the reference divider on ref_clk.
// Assumes: rst_n is held across several edges of both clocks; configuration
// inputs are quasi-static and are sampled by each divider only at its reload.
module pll_div_core
    import pllcnt_pkg::*;
#(
    parameter int P_W       = 8,
    parameter int Q_W       = 6,
    parameter int FB_OFS    = 3,
    parameter int FB_SCALE  = 2,
    parameter int Q_OFS     = 2,
    parameter int PIN0_MULT = 16,
    parameter int PIN1_MULT = 8,
    localparam int FB_PMAX  = (((1 << P_W) - 1) + FB_OFS) * FB_SCALE,
    localparam int PIN_MAX  = (PIN0_MULT > PIN1_MULT) ? PIN0_MULT : PIN1_MULT,
    localparam int FB_MAX   = (FB_PMAX > PIN_MAX) ? FB_PMAX : PIN_MAX,
    localparam int REF_MAX  = ((1 << Q_W) - 1) + Q_OFS,
    localparam int FB_W     = $clog2(FB_MAX + 1),
    localparam int REF_W    = $clog2(REF_MAX + 1)
) (
    input  logic             vco_clk,
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             prog_en,
    input  logic             mult_sel,
    input  logic             q_bypass,
    input  logic [P_W-1:0]   cfg_p,
    input  logic [Q_W-1:0]   cfg_q,
    output logic             fb_pulse,
    output logic             fb_half,
    output logic             ref_pulse,
    output logic [FB_W-1:0]  fb_ratio,
    output logic [REF_W-1:0] ref_ratio
);

    logic ref_half_unused;

    pll_ratio_sel #(
        .P_W       (P_W),
        .Q_W       (Q_W),
        .FB_W      (FB_W),
        .REF_W     (REF_W),
        .FB_OFS    (FB_OFS),
        .FB_SCALE  (FB_SCALE),
        .Q_OFS     (Q_OFS),
        .PIN0_MULT (PIN0_MULT),
        .PIN1_MULT (PIN1_MULT)
    ) u_sel (
        .cfg_p     (cfg_p),
        .cfg_q     (cfg_q),
        .prog_en   (prog_en),
        .q_bypass  (q_bypass),
        .mult_sel  (mult_sel),
        .fb_ratio  (fb_ratio),
        .ref_ratio (ref_ratio)
    );

    pll_down_div #(
        .CNT_W    (FB_W),
        .HAS_HALF (1'b1)
    ) u_fb_div (
        .clk      (vco_clk),
        .rst_n    (rst_n),
        .ratio_in (fb_ratio),
        .tc_pulse (fb_pulse),
        .half_out (fb_half)
    );

    pll_down_div #(
        .CNT_W    (REF_W),
        .HAS_HALF (1'b0)
    ) u_ref_div (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .ratio_in (ref_ratio),
        .tc_pulse (ref_pulse),
        .half_out (ref_half_unused)
    );

endmodule

// File: rtl/pll_div_core_chk.sv
// Module pll_div_core_chk
// Property checker bound to pll_div_core. It keeps its own record of the ratio
// seen at each reload and of the pulse spacing in each clock domain.
module pll_div_core_chk #(
    parameter int FB_W      = 10,
    parameter int REF_W     = 7,
    parameter int PIN0_MULT = 16,
    parameter int PIN1_MULT = 8
) (
    input logic             vco_clk,
    input logic             ref_clk,
    input logic             rst_n,
    input logic             prog_en,
    input logic             mult_sel,
    input logic             q_bypass,
    input logic             fb_pulse,
    input logic             fb_half,
    input logic             ref_pulse,
    input logic [FB_W-1:0]  fb_ratio,
    input logic [REF_W-1:0] ref_ratio
);

    logic [FB_W-1:0]  fb_prev, fb_shadow, fb_gap;
    logic             fb_seen;
    logic [REF_W-1:0] ref_prev, ref_shadow, ref_gap;
    logic             ref_seen;

    // Feedback domain: ratio at the reload edge and cycles since the last pulse.
    always_ff @(posedge vco_clk) begin
        if (!rst_n) begin
            fb_prev <= '0; fb_shadow <= '0; fb_gap <= '0; fb_seen <= 1'b0;
        end else begin
            fb_prev <= fb_ratio;
            if (fb_pulse) begin
                fb_gap    <= FB_W'(1);
                fb_shadow <= fb_prev;
                fb_seen   <= 1'b1;
            end else begin
                fb_gap <= fb_gap + FB_W'(1);
            end
        end
    end

    // Reference domain: same bookkeeping on ref_clk.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            ref_prev <= '0; ref_shadow <= '0; ref_gap <= '0; ref_seen <= 1'b0;
        end else begin
            ref_prev <= ref_ratio;
            if (ref_pulse) begin
                ref_gap    <= REF_W'(1);
                ref_shadow <= ref_prev;
                ref_seen   <= 1'b1;
            end else begin
                ref_gap <= ref_gap + REF_W'(1);
            end
        end
    end

    // R1: a programmed feedback ratio is even and non-zero.
    p_fb_even_r1: assert property (@(posedge vco_clk) disable iff (!rst_n)
        prog_en |-> (fb_ratio[0] == 1'b0 && fb_ratio != '0));

    // R3: bypass forces unity reference.
    p_ref_bypass_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (prog_en && q_bypass) |-> (ref_ratio == REF_W'(1)));

    // R4: pin mode gives unity reference and a fixed multiplier.
    p_pin_mode_r4: assert property (@(posedge vco_clk) disable iff (!rst_n)
        !prog_en |-> (ref_ratio == REF_W'(1) &&
                      fb_ratio == (mult_sel ? FB_W'(PIN1_MULT) : FB_W'(PIN0_MULT))));

    // R6 / R7: each feedback pulse ends a period of the ratio taken at the previous reload.
    p_fb_spacing_r7: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (fb_pulse && fb_seen) |-> (fb_gap == fb_shadow));

    // R6 / R7: same on the reference side.
    p_ref_spacing_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (ref_pulse && ref_seen) |-> (ref_gap == ref_shadow));

    // R8: the square wave flips together with every feedback pulse.
    p_half_flip_r8: assert property (@(posedge vco_clk) disable iff (!rst_n)
        fb_pulse |-> (fb_half != $past(fb_half)));

endmodule

bind pll_div_core pll_div_core_chk #(
    .FB_W      (FB_W),
    .REF_W     (REF_W),
    .PIN0_MULT (PIN0_MULT),
    .PIN1_MULT (PIN1_MULT)
) u_chk (
    .vco_clk   (vco_clk),
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .prog_en   (prog_en),
    .mult_sel  (mult_sel),
    .q_bypass  (q_bypass),
    .fb_pulse  (fb_pulse),
    .fb_half   (fb_half),
    .ref_pulse (ref_pulse),
    .fb_ratio  (fb_ratio),
    .ref_ratio (ref_ratio)
);

// File: tb/tb_pll_div_core.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected pulse spacings, and one
// monitor per clock domain pops and compares them at each pulse.
module tb_pll_div_core;

    logic       vco_clk = 1'b0;
    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       prog_en = 1'b0;
    logic       mult_sel = 1'b1;
    logic       q_bypass = 1'b0;
    logic [7:0] cfg_p = '0;
    logic [5:0] cfg_q = '0;
    logic       fb_pulse, fb_half, ref_pulse;
    logic [9:0] fb_ratio;
    logic [6:0] ref_ratio;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    int    fb_q[$];
    string fb_tag_q[$];
    int    ref_q[$];
    int    fb_cur = 8;
    int    fb_since = 0, ref_since = 0;
    bit    fb_seen = 1'b0, ref_seen = 1'b0;
    int    exp_v;
    string exp_t;

    always #2 vco_clk = ~vco_clk;   // 250 MHz
    always #8 ref_clk = ~ref_clk;

    pll_div_core dut (
        .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n),
        .prog_en(prog_en), .mult_sel(mult_sel), .q_bypass(q_bypass),
        .cfg_p(cfg_p), .cfg_q(cfg_q),
        .fb_pulse(fb_pulse), .fb_half(fb_half), .ref_pulse(ref_pulse),
        .fb_ratio(fb_ratio), .ref_ratio(ref_ratio)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Feedback monitor: measure the spacing of pulses and compare it with the queue.
    always @(negedge vco_clk) begin
        if (rst_n) begin
            fb_since++;
            if (fb_pulse) begin
                if (fb_seen && fb_q.size() > 0) begin
                    exp_v = fb_q.pop_front();
                    exp_t = fb_tag_q.pop_front();
                    check(exp_t, fb_since, exp_v);
                end
                fb_seen  = 1'b1;
                fb_since = 0;
            end
        end
    end

    // Reference monitor.
    always @(negedge ref_clk) begin
        if (rst_n) begin
            ref_since++;
            if (ref_pulse) begin
                if (ref_seen && ref_q.size() > 0)
                    check("R6 ref spacing", ref_since, ref_q.pop_front());
                ref_seen  = 1'b1;
                ref_since = 0;
            end
        end
    end

    // Driver: apply a configuration right after a feedback pulse and push the expected spacings.
    task automatic apply_cfg(input logic en, input logic sel, input logic byp,
                             input logic [7:0] p, input logic [5:0] q,
                             input int exp_fb, input int exp_ref, input string req);
        do @(negedge vco_clk); while (fb_pulse !== 1'b1);
        #1;
        prog_en = en; mult_sel = sel; q_bypass = byp; cfg_p = p; cfg_q = q;
        #1;
        check({req, " fb_ratio"}, int'(fb_ratio), exp_fb);
        check({req, " ref_ratio"}, int'(ref_ratio), exp_ref);
        fb_q.push_back(fb_cur);                 // R7: the running period keeps the old ratio
        fb_tag_q.push_back("R7 old period kept");
        for (int i = 0; i < 3; i++) begin
            fb_q.push_back(exp_fb);
            fb_tag_q.push_back("R6 fb spacing");
        end
        fb_cur = exp_fb;
        for (int k = 0; k < 2; k++) begin
            do @(negedge ref_clk); while (ref_pulse !== 1'b1);
        end
        #1;
        for (int i = 0; i < 3; i++) ref_q.push_back(exp_ref);
        while (fb_q.size() != 0 || ref_q.size() != 0) @(negedge vco_clk);
    endtask

    // Measure how many cycles fb_half stays high.
    task automatic measure_half(input int exp);
        int cnt;
        do @(negedge vco_clk); while (fb_half !== 1'b0);
        do @(negedge vco_clk); while (fb_half !== 1'b1);
        cnt = 0;
        while (fb_half === 1'b1) begin
            cnt++;
            @(negedge vco_clk);
        end
        check("R8 fb_half high time", cnt, exp);
    endtask

    initial begin
        repeat (6) @(negedge vco_clk);
        check("R5 fb_pulse in reset", int'(fb_pulse), 0);
        check("R5 ref_pulse in reset", int'(ref_pulse), 0);
        check("R5 fb_half in reset", int'(fb_half), 0);
        #1 rst_n = 1'b1;
        fork
            begin
                @(posedge ref_clk); #1;
                check("R9 first ref pulse", int'(ref_pulse), 1);
            end
            begin
                @(posedge vco_clk); #1;
                check("R9 first fb pulse", int'(fb_pulse), 1);
                @(posedge vco_clk); #1;
                check("R6 fb pulse one cycle", int'(fb_pulse), 0);
            end
        join
        check("R4 pin sel1 fb_ratio", int'(fb_ratio), 8);

        apply_cfg(1'b0, 1'b0, 1'b0, 8'd0,   6'd0,  16,  1, "R4 pin sel0");
        apply_cfg(1'b0, 1'b0, 1'b1, 8'd200, 6'd40, 16,  1, "R4 fields ignored");
        apply_cfg(1'b1, 1'b0, 1'b0, 8'd0,   6'd0,  6,   2, "R1 R2 min");
        apply_cfg(1'b1, 1'b0, 1'b0, 8'd255, 6'd63, 516, 65, "R1 R2 max");
        measure_half(258);
        apply_cfg(1'b1, 1'b1, 1'b1, 8'd10,  6'd5,  26,  1, "R3 bypass");
        apply_cfg(1'b1, 1'b0, 1'b0, 8'd37,  6'd1,  80,  3, "R1 R2 mid");
        measure_half(40);
        apply_cfg(1'b0, 1'b1, 1'b0, 8'd37,  6'd1,  8,   1, "R4 pin sel1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule